// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirector

This block watches a set of interrupt input lines and turns each qualifying assertion into one posted write, a message-signalled interrupt, addressed to a processor. Every line owns a redirection entry. The entry holds the message data byte, the input polarity, the trigger mode, a mask bit and a two-byte destination made of a processor ID and an extended ID. Software reaches the block through a small register port with three 32-bit registers. An index register picks an internal word. A window register reads or writes the picked word. An end-of-interrupt register re-arms a level-triggered line.

Edge-triggered lines send one message for each inactive-to-active transition. A level-triggered line sends one message and then goes into service. It stays silent until software writes that line's number to the end-of-interrupt register. If the line is still active at that point, the line fires again. Software uses this at enable time so that a line already asserted is not lost. The outgoing message leaves on a valid/ready port. When several lines request in the same cycle, a fixed priority picks the lowest line number first.

Top module: `lmr_top`

## Requirements
- R1: After reset, every entry reads back with only its mask bit (bit 16 of the low word) set, the high words read zero, the index register reads zero, and no message is sent even when inputs toggle.
- R2: Index 0x01 through the window (offset 0x10) returns the version word: bits 7:0 hold the VERSION parameter, bits 23:16 hold NUM_LINES-1, and all other bits are zero.
- R3: Index register at offset 0x00 (bits 7:0). For line n, index 0x10+2n is the low word: vector in bits 7:0, active-low in bit 13, level trigger in bit 15, mask in bit 16. Index 0x11+2n is the high word: destination ID in bits 31:24, extended ID in bits 23:16. A window read after a write returns the value written in those fields. An index that is not implemented reads zero.
- R4: Each message carries msg_addr = {destination ID, extended ID} and msg_data = vector of the line that raised it.
- R5: An unmasked edge-triggered line sends exactly one message per inactive-to-active transition, however long it then stays active.
- R6: With the active-low bit set, a line counts as active when its input is 0. With the bit clear, it counts as active when its input is 1.
- R7: An unmasked level-triggered line sends one message when it becomes active. It then sends no further message while it stays active, until an end-of-interrupt write.
- R8: Writing line n's number to offset 0x40 re-arms a level line n. If the line is still active, one new message follows. If it is inactive, no message follows until it becomes active again.
- R9: End-of-interrupt writes have no effect on edge-triggered lines: no message results.
- R10: A masked line sends no message. An edge that occurs while the line is masked is dropped. A level line that is still active when it is unmasked fires.
- R11: When several lines request at once, messages go out one at a time in ascending line order.
- R12: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_addr and msg_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_in | input | NUM_LINES | Interrupt input lines |
| msg_valid | output | 1 | Message write valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 16 | Message address {ID, extended ID} |
| msg_data | output | 8 | Message data (vector) |

## Verification
The bench builds the block with NUM_LINES = 4 and VERSION = 8'h5A. With four lines it can sweep every line through both polarities and both trigger modes, each line with its own computed vector and destination. It can also read every implemented index and index holes on both sides of the table. All four lines can be raised in a single cycle under backpressure, which drives the full priority order and the hold-stable rule.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;
    localparam logic [7:0] OFS_EOI    = 8'h40;

    localparam logic [7:0] IDX_VERSION = 8'h01;
    localparam logic [7:0] IDX_TABLE   = 8'h10;

    localparam int BIT_ACT_LOW = 13;
    localparam int BIT_LEVEL   = 15;
    localparam int BIT_MASK    = 16;

    typedef struct packed {
        logic [7:0] vec;
        logic       act_low;
        logic       level;
        logic       mask;
        logic [7:0] dst_id;
        logic [7:0] dst_eid;
    } lmr_entry_t;

    localparam lmr_entry_t ENTRY_RESET = '{vec: 8'h00, act_low: 1'b0, level: 1'b0,
                                           mask: 1'b1, dst_id: 8'h00, dst_eid: 8'h00};

endpackage

// File: rtl/lmr_regs.sv
module lmr_regs
    import lmr_pkg::*;
#(
    parameter int         NUM_LINES = 7,
    parameter logic [7:0] VERSION   = 8'h21
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [7:0]                   addr,
    input  logic [31:0]                  wdata,
    output logic [31:0]                  rdata,
    output lmr_entry_t [NUM_LINES-1:0]   entries,
    output logic [NUM_LINES-1:0]         eoi
);

    localparam logic [7:0] MAX_ENTRY = 8'(NUM_LINES - 1);

    typedef struct packed {
        logic [7:0]                 sel;
        lmr_entry_t [NUM_LINES-1:0] tbl;
    } regs_t;

    regs_t st_d, st_q;

    logic [7:0] win_off;
    logic [6:0] win_line;
    logic       win_hi;
    logic       win_in_tbl;

    assign win_off    = st_q.sel - IDX_TABLE;
    assign win_line   = win_off[7:1];
    assign win_hi     = win_off[0];
    assign win_in_tbl = (st_q.sel >= IDX_TABLE);

    always_comb begin
        st_d = st_q;
        eoi  = '0;
        if (wr_en) begin
            if (addr == OFS_SELECT) begin
                st_d.sel = wdata[7:0];
            end else if (addr == OFS_WINDOW) begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (win_in_tbl && (win_line == 7'(i))) begin
                        if (win_hi) begin
                            st_d.tbl[i].dst_id  = wdata[31:24];
                            st_d.tbl[i].dst_eid = wdata[23:16];
                        end else begin
                            st_d.tbl[i].vec     = wdata[7:0];
                            st_d.tbl[i].act_low = wdata[BIT_ACT_LOW];
                            st_d.tbl[i].level   = wdata[BIT_LEVEL];
                            st_d.tbl[i].mask    = wdata[BIT_MASK];
                        end
                    end
                end
            end else if (addr == OFS_EOI) begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (wdata == 32'(i)) begin
                        eoi[i] = 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_SELECT) begin
            rdata = {24'h0, st_q.sel};
        end else if (addr == OFS_WINDOW) begin
            if (st_q.sel == IDX_VERSION) begin
                rdata = {8'h00, MAX_ENTRY, 8'h00, VERSION};
            end
            for (int i = 0; i < NUM_LINES; i++) begin
                if (win_in_tbl && (win_line == 7'(i))) begin
                    if (win_hi) begin
                        rdata = {st_q.tbl[i].dst_id, st_q.tbl[i].dst_eid, 16'h0000};
                    end else begin
                        rdata = {15'h0, st_q.tbl[i].mask, st_q.tbl[i].level, 1'b0,
                                 st_q.tbl[i].act_low, 5'h00, st_q.tbl[i].vec};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                st_q.tbl[i] <= ENTRY_RESET;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign entries = st_q.tbl;

    a_r9_eoi_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eoi));

endmodule

// File: rtl/lmr_line.sv
module lmr_line
    import lmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq,
    input  lmr_entry_t cfg,
    input  logic       eoi,
    input  logic       grant,
    output logic       req
);

    typedef struct packed {
        logic prev_act;
        logic pending;
        logic in_svc;
    } line_t;

    line_t st_d, st_q;
    logic  act;
    logic  rise;

    assign act  = irq ^ cfg.act_low;
    assign rise = act & ~st_q.prev_act;

    always_comb begin
        st_d          = st_q;
        st_d.prev_act = act;
        if (cfg.level) begin
            req          = act & ~st_q.in_svc & ~cfg.mask;
            st_d.pending = 1'b0;
            if (grant) begin
                st_d.in_svc = 1'b1;
            end else if (eoi) begin
                st_d.in_svc = 1'b0;
            end
        end else begin
            req          = st_q.pending & ~cfg.mask;
            st_d.pending = (st_q.pending & ~grant) | (rise & ~cfg.mask);
            st_d.in_svc  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: once served, a level line stays quiet until an end-of-interrupt arrives
    a_r7_quiet_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.level && st_q.in_svc && !eoi) |=> !(grant && $past(cfg.level)));

endmodule

// File: rtl/lmr_arb.sv
module lmr_arb
    import lmr_pkg::*;
#(
    parameter int NUM_LINES = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LINES-1:0]       req,
    input  lmr_entry_t [NUM_LINES-1:0] entries,
    input  logic                       ready,
    output logic [NUM_LINES-1:0]       grant,
    output logic                       valid,
    output logic [15:0]                addr,
    output logic [7:0]                 data
);

    typedef struct packed {
        logic        valid;
        logic [15:0] addr;
        logic [7:0]  data;
    } out_t;

    out_t st_d, st_q;
    logic slot_free;
    logic found;

    assign slot_free = ~st_q.valid | ready;

    always_comb begin
        st_d  = st_q;
        grant = '0;
        found = 1'b0;
        if (ready) begin
            st_d.valid = 1'b0;
        end
        if (slot_free) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (req[i] && !found) begin
                    found      = 1'b1;
                    grant[i]   = 1'b1;
                    st_d.valid = 1'b1;
                    st_d.addr  = {entries[i].dst_id, entries[i].dst_eid};
                    st_d.data  = entries[i].vec;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign addr  = st_q.addr;
    assign data  = st_q.data;

    a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r11_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(addr) && $stable(data)));

    a_r12_drop_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> $past(ready));

endmodule

// File: rtl/lmr_top.sv
module lmr_top
    import lmr_pkg::*;
#(
    parameter int         NUM_LINES = 7,
    parameter logic [7:0] VERSION   = 8'h21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [15:0]          msg_addr,
    output logic [7:0]           msg_data
);

    lmr_entry_t [NUM_LINES-1:0] entries;
    logic [NUM_LINES-1:0]       eoi;
    logic [NUM_LINES-1:0]       req;
    logic [NUM_LINES-1:0]       grant;
    logic [NUM_LINES-1:0]       mask_vec;

    lmr_regs #(
        .NUM_LINES (NUM_LINES),
        .VERSION   (VERSION)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .entries (entries),
        .eoi     (eoi)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        lmr_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .irq   (irq_in[g]),
            .cfg   (entries[g]),
            .eoi   (eoi[g]),
            .grant (grant[g]),
            .req   (req[g])
        );
        assign mask_vec[g] = entries[g].mask;
    end

    lmr_arb #(
        .NUM_LINES (NUM_LINES)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .entries (entries),
        .ready   (msg_ready),
        .grant   (grant),
        .valid   (msg_valid),
        .addr    (msg_addr),
        .data    (msg_data)
    );

    a_r10_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & mask_vec) == '0);

endmodule

// File: tb/lmr_top_tb.sv
module lmr_top_tb;

    localparam int         NL  = 4;
    localparam logic [7:0] VER = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NL-1:0] irq_in = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [15:0] msg_addr;
    logic [7:0]  msg_data;

    int checks = 0;
    int fails  = 0;
    int log_n  = 0;
    logic [15:0] log_addr [128];
    logic [7:0]  log_data [128];

    always #5 clk = ~clk;

    lmr_top #(.NUM_LINES(NL), .VERSION(VER)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_in    (irq_in),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            log_addr[log_n % 128] = msg_addr;
            log_data[log_n % 128] = msg_data;
            log_n = log_n + 1;
        end
    end

    function automatic logic [7:0] vec_of(int n);
        return 8'(8'h40 + n);
    endfunction
    function automatic logic [15:0] dst_of(int n);
        return {8'(8'h80 + 3 * n), 8'(5 * n + 1)};
    endfunction
    function automatic logic [31:0] low_word(int n, bit pol, bit lvl, bit msk);
        return 32'(vec_of(n)) | (32'(pol) << 13) | (32'(lvl) << 15) | (32'(msk) << 16);
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic win_wr(logic [7:0] idx, logic [31:0] d);
        wr(8'h00, 32'(idx));
        wr(8'h10, d);
    endtask

    task automatic win_rd(logic [7:0] idx, output logic [31:0] d);
        wr(8'h00, 32'(idx));
        rd(8'h10, d);
    endtask

    // program a line masked, settle input to inactive, then optionally unmask
    task automatic setup_line(int n, bit pol, bit lvl, bit unmask);
        win_wr(8'(16 + 2 * n), low_word(n, pol, lvl, 1'b1));
        irq_in[n] = pol;
        tick(2);
        if (unmask) win_wr(8'(16 + 2 * n), low_word(n, pol, lvl, 1'b0));
    endtask

    task automatic check_msg(string req, int idx, int n);
        check(req, 32'(log_addr[idx % 128]), 32'(dst_of(n)));
        check(req, 32'(log_data[idx % 128]), 32'(vec_of(n)));
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int base;
        logic [15:0] held_addr;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        rd(8'h00, d);
        check("R1 select", d, 32'h0);
        for (int n = 0; n < NL; n++) begin
            win_rd(8'(16 + 2 * n), d);
            check("R1 low word", d, 32'h0001_0000);
            win_rd(8'(17 + 2 * n), d);
            check("R1 high word", d, 32'h0);
        end
        base = log_n;
        irq_in = '1; tick(4); irq_in = '0; tick(4);
        check("R1 no message", 32'(log_n - base), 32'd0);
        check("R1 valid low", 32'(msg_valid), 32'd0);

        // R2: version word
        win_rd(8'h01, d);
        check("R2 version", d, {8'h00, 8'(NL - 1), 8'h00, VER});

        // R3: readback and holes
        for (int n = 0; n < NL; n++) begin
            win_wr(8'(16 + 2 * n), low_word(n, n[0], n[1], 1'b1));
            win_wr(8'(17 + 2 * n), {dst_of(n), 16'h0});
        end
        for (int n = 0; n < NL; n++) begin
            win_rd(8'(16 + 2 * n), d);
            check("R3 low readback", d, low_word(n, n[0], n[1], 1'b1));
            win_rd(8'(17 + 2 * n), d);
            check("R3 high readback", d, {dst_of(n), 16'h0});
        end
        win_rd(8'h02, d);
        check("R3 hole below table", d, 32'h0);
        win_rd(8'(16 + 2 * NL), d);
        check("R3 hole past table", d, 32'h0);
        rd(8'h40, d);
        check("R3 eoi reads zero", d, 32'h0);
        for (int n = 0; n < NL; n++) win_wr(8'(16 + 2 * n), low_word(n, 1'b0, 1'b0, 1'b1));
        irq_in = '0;
        tick(2);

        // R4 R5 R6 R9: edge lines, both polarities
        for (int n = 0; n < NL; n++) begin
            for (int p = 0; p < 2; p++) begin
                setup_line(n, p[0], 1'b0, 1'b1);
                base = log_n;
                irq_in[n] = ~p[0];
                tick(8);
                check("R5 R6 one message", 32'(log_n - base), 32'd1);
                check_msg("R4 content", base, n);
                tick(6);
                check("R5 no repeat while held", 32'(log_n - base), 32'd1);
                irq_in[n] = p[0]; tick(3);
                irq_in[n] = ~p[0]; tick(8);
                check("R5 second transition", 32'(log_n - base), 32'd2);
                wr(8'h40, 32'(n));
                tick(8);
                check("R9 eoi ignored", 32'(log_n - base), 32'd2);
                win_wr(8'(16 + 2 * n), low_word(n, p[0], 1'b0, 1'b1));
                irq_in[n] = 1'b0;
                tick(2);
            end
        end

        // R7 R8: level lines
        for (int n = 0; n < NL; n++) begin
            for (int p = 0; p < 2; p++) begin
                setup_line(n, p[0], 1'b1, 1'b1);
                base = log_n;
                irq_in[n] = ~p[0];
                tick(8);
                check("R7 first message", 32'(log_n - base), 32'd1);
                check_msg("R4 level content", base, n);
                tick(10);
                check("R7 quiet in service", 32'(log_n - base), 32'd1);
                wr(8'h40, 32'(n));
                tick(8);
                check("R8 refire active", 32'(log_n - base), 32'd2);
                irq_in[n] = p[0]; tick(2);
                wr(8'h40, 32'(n));
                tick(8);
                check("R8 no refire inactive", 32'(log_n - base), 32'd2);
                irq_in[n] = ~p[0];
                tick(8);
                check("R8 fires on reactivation", 32'(log_n - base), 32'd3);
                win_wr(8'(16 + 2 * n), low_word(n, p[0], 1'b1, 1'b1));
                irq_in[n] = p[0];
                wr(8'h40, 32'(n));
                irq_in[n] = 1'b0;
                tick(2);
            end
        end

        // R10: masking
        setup_line(1, 1'b0, 1'b1, 1'b0);
        base = log_n;
        irq_in[1] = 1'b1;
        tick(8);
        check("R10 masked level silent", 32'(log_n - base), 32'd0);
        win_wr(8'h12, low_word(1, 1'b0, 1'b1, 1'b0));
        tick(8);
        check("R10 level fires on unmask", 32'(log_n - base), 32'd1);
        win_wr(8'h12, low_word(1, 1'b0, 1'b1, 1'b1));
        irq_in[1] = 1'b0;
        wr(8'h40, 32'd1);
        setup_line(2, 1'b0, 1'b0, 1'b0);
        base = log_n;
        irq_in[2] = 1'b1; tick(3); irq_in[2] = 1'b0; tick(2);
        win_wr(8'h14, low_word(2, 1'b0, 1'b0, 1'b0));
        tick(8);
        check("R10 masked edge dropped", 32'(log_n - base), 32'd0);

        // R11 R12: simultaneous requests under backpressure
        for (int n = 0; n < NL; n++) setup_line(n, 1'b0, 1'b0, 1'b1);
        msg_ready = 1'b0;
        base = log_n;
        irq_in = '1;
        tick(4);
        check("R12 valid held", 32'(msg_valid), 32'd1);
        check("R11 lowest first", 32'(msg_data), 32'(vec_of(0)));
        held_addr = msg_addr;
        tick(5);
        check("R12 still valid", 32'(msg_valid), 32'd1);
        check("R12 addr stable", 32'(msg_addr), 32'(held_addr));
        check("R12 data stable", 32'(msg_data), 32'(vec_of(0)));
        check("R12 none accepted", 32'(log_n - base), 32'd0);
        msg_ready = 1'b1;
        tick(10);
        check("R11 all delivered", 32'(log_n - base), 32'(NL));
        for (int n = 0; n < NL; n++) check_msg("R11 order", base + n, n);
        check("R11 idle after", 32'(msg_valid), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule